// File: doc/BRIEF.md
# Glitch-free dynamic clock selector

This block produces one output clock from two free-running input clocks that have no phase or frequency relation to each other. A compile-time mode chooses how the selection input is used: two modes switch between the inputs with a synchronised, break-before-make handover; four modes gate a single input on or off and park the output at a fixed level when it is off; two modes pass one input straight through and ignore the selection input.

In the two switching modes each input clock has its own lane. A lane carries a short synchroniser chain that brings its enable request into that lane's clock domain. A lane's request is only raised once the other lane's enable has dropped. While neither lane is enabled, the output rests at the mode's idle level, so the output carries no pulse shorter than a half period of either input. An active-high asynchronous reset clears every lane, which puts the output at its idle level. After reset is released, the lane named by the selection input at that moment takes over.

Top module: `dyn_clk_select`

## Requirements
- R1: In mode SEL_EDGE_RISE, once pick_b has been stable long enough for the handover to finish, clk_out equals clk_a while pick_b is 0 and clk_b while pick_b is 1.
- R2: In mode SEL_EDGE_RISE, lane enables change only on rising edges of their own clock. clk_out is 1 whenever neither lane is enabled, including throughout reset.
- R3: In mode SEL_EDGE_FALL, clk_out follows clk_a for pick_b 0 and clk_b for pick_b 1 once settled. Lane enables change on falling edges, and clk_out is 0 whenever neither lane is enabled, including throughout reset.
- R4: In the two switching modes the two lane enables are never both on. Every high or low pulse on clk_out lasts at least the shorter of the two input half periods.
- R5: In modes SEL_HIACT_LOW and SEL_HIACT_HIGH, pick_b 1 passes clk_b. With pick_b 0, or during reset, the output is forced to 0 (SEL_HIACT_LOW) or to 1 (SEL_HIACT_HIGH).
- R6: In modes SEL_LOACT_LOW and SEL_LOACT_HIGH, pick_b 0 passes clk_a. With pick_b 1, or during reset, the output is forced to 0 (SEL_LOACT_LOW) or to 1 (SEL_LOACT_HIGH).
- R7: Mode SEL_FIXED_A always drives clk_a and mode SEL_FIXED_B always drives clk_b. Neither pick_b nor arst has any effect on them.
- R8: Each lane passes its request through SYNC_STAGES flops (at least 2) of its own clock. After arst falls, the lane chosen by the pick_b value present then is enabled, and clk_out follows that input without any further intervention.
- R9: The mode parameter MODE defaults to SEL_EDGE_RISE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First free-running input clock |
| clk_b | input | 1 | Second free-running input clock, unrelated to clk_a |
| pick_b | input | 1 | Selection input: 0 names clk_a, 1 names clk_b (use depends on MODE) |
| arst | input | 1 | Active-high asynchronous reset |
| clk_out | output | 1 | Selected or gated output clock |

## Verification
The assertions on lane exclusivity, on the resting level and on output-follows-lane assume that pick_b stays put between changes for longer than a complete handover. That is about 2·SYNC_STAGES+2 periods of the slower input. Under that assumption a request never overtakes an enable that is still moving through the other lane's synchroniser. The stimulus toggles pick_b at random moments but keeps every hold time at 400 ns or more, against a slower input of roughly 30 MHz. Input clock phases are offset so that no clock edge coincides with a bench sampling instant.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

  // Operating variants of the selector, fixed at elaboration time.
  typedef enum logic [2:0] {
    SEL_EDGE_RISE,   // switch a<->b on rising edges, rest high
    SEL_EDGE_FALL,   // switch a<->b on falling edges, rest low
    SEL_HIACT_LOW,   // pick_b=1 passes clk_b, else 0
    SEL_HIACT_HIGH,  // pick_b=1 passes clk_b, else 1
    SEL_LOACT_LOW,   // pick_b=0 passes clk_a, else 0
    SEL_LOACT_HIGH,  // pick_b=0 passes clk_a, else 1
    SEL_FIXED_A,     // always clk_a
    SEL_FIXED_B      // always clk_b
  } clksel_mode_e;

  function automatic logic is_dual(clksel_mode_e m);
    return (m == SEL_EDGE_RISE) || (m == SEL_EDGE_FALL);
  endfunction

  function automatic logic is_gated(clksel_mode_e m);
    return (m == SEL_HIACT_LOW) || (m == SEL_HIACT_HIGH) ||
           (m == SEL_LOACT_LOW) || (m == SEL_LOACT_HIGH);
  endfunction

  // Gated variants that act on clk_b (active-high select).
  function automatic logic gated_on_b(clksel_mode_e m);
    return (m == SEL_HIACT_LOW) || (m == SEL_HIACT_HIGH);
  endfunction

  // Level clk_out rests at when no lane is enabled.
  function automatic logic off_level(clksel_mode_e m);
    return (m == SEL_EDGE_RISE) || (m == SEL_HIACT_HIGH) ||
           (m == SEL_LOACT_HIGH);
  endfunction

  // A lane that rests high must retime its enable while its clock is high,
  // i.e. on the rising edge; a lane that rests low retimes on the falling edge.
  function automatic logic lane_rising(clksel_mode_e m);
    return off_level(m);
  endfunction

endpackage

// File: rtl/clksel_lane.sv
`timescale 1ns/1ps
// One clock lane: synchronises an enable request into its own clock domain
// and gates that clock so the enable only moves while the clock already sits
// at the lane's resting level.
module clksel_lane #(
  parameter int STAGES = 2,    // synchroniser depth, at least 2
  parameter bit RISE   = 1'b1  // 1: retime on rising edge, rest high
) (
  input  logic clk,
  input  logic arst,
  input  logic want,
  output logic gate_on,
  output logic lane_clk
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] pipe;

  if (RISE) begin : g_rise
    always_ff @(posedge clk or posedge arst) begin
      if (arst) pipe <= '0;
      else      pipe <= {pipe[LAST-1:0], want};
    end
    // Disabled lane contributes a constant 1 to the AND tree.
    assign lane_clk = clk | ~gate_on;
  end else begin : g_fall
    always_ff @(negedge clk or posedge arst) begin
      if (arst) pipe <= '0;
      else      pipe <= {pipe[LAST-1:0], want};
    end
    // Disabled lane contributes a constant 0 to the OR tree.
    assign lane_clk = clk & gate_on;
  end

  assign gate_on = pipe[LAST];

endmodule

// File: rtl/dyn_clk_select.sv
`timescale 1ns/1ps
module dyn_clk_select
  import clksel_pkg::*;
#(
  parameter clksel_mode_e MODE        = SEL_EDGE_RISE,
  parameter int           SYNC_STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic pick_b,
  input  logic arst,
  output logic clk_out
);

  localparam logic IDLE_LVL   = off_level(MODE);
  localparam bit   RISE_LANES = lane_rising(MODE);

  // Named internal events, visible to the assertions below.
  logic gate_a;      // lane a enabled
  logic gate_b;      // lane b enabled
  logic lane_a_clk;  // gated contribution of clk_a
  logic lane_b_clk;  // gated contribution of clk_b

  if (is_dual(MODE)) begin : g_dual
    logic want_a, want_b;

    // Break-before-make: a lane asks only once the other has let go.
    assign want_a = ~pick_b & ~gate_b;
    assign want_b =  pick_b & ~gate_a;

    clksel_lane #(.STAGES(SYNC_STAGES), .RISE(RISE_LANES)) u_lane_a (
      .clk(clk_a), .arst(arst), .want(want_a),
      .gate_on(gate_a), .lane_clk(lane_a_clk)
    );
    clksel_lane #(.STAGES(SYNC_STAGES), .RISE(RISE_LANES)) u_lane_b (
      .clk(clk_b), .arst(arst), .want(want_b),
      .gate_on(gate_b), .lane_clk(lane_b_clk)
    );

    if (RISE_LANES) begin : g_and
      assign clk_out = lane_a_clk & lane_b_clk;
    end else begin : g_or
      assign clk_out = lane_a_clk | lane_b_clk;
    end

    // R4: never both lanes on, seen from either domain.
    a_r4_exclusive_a: assert property (@(posedge clk_a) disable iff (arst)
      !(gate_a && gate_b));
    a_r4_exclusive_b: assert property (@(posedge clk_b) disable iff (arst)
      !(gate_a && gate_b));
    // R2 (and R3 for the falling variant): resting level while handing over.
    a_r2_held_level: assert property (@(posedge clk_b) disable iff (arst)
      (!gate_a && !gate_b) |-> (clk_out == IDLE_LVL));
    // R1 (R3): once lane b owns the output, it carries clk_b.
    a_r1_follow_b: assert property (@(posedge clk_a) disable iff (arst)
      (gate_b && !gate_a) |-> (clk_out == clk_b));
    a_r1_follow_a: assert property (@(posedge clk_b) disable iff (arst)
      (gate_a && !gate_b) |-> (clk_out == clk_a));

  end else if (is_gated(MODE)) begin : g_gated

    if (gated_on_b(MODE)) begin : g_on_b
      clksel_lane #(.STAGES(SYNC_STAGES), .RISE(RISE_LANES)) u_lane_b (
        .clk(clk_b), .arst(arst), .want(pick_b),
        .gate_on(gate_b), .lane_clk(lane_b_clk)
      );
      assign gate_a     = 1'b0;
      assign lane_a_clk = IDLE_LVL;
      assign clk_out    = lane_b_clk;

      if (RISE_LANES) begin : g_chk_hi
        a_r5_forced_high: assert property (@(posedge clk_b) disable iff (arst)
          !gate_b |-> clk_out);
      end else begin : g_chk_lo
        a_r5_forced_low: assert property (@(negedge clk_b) disable iff (arst)
          !gate_b |-> !clk_out);
      end
    end else begin : g_on_a
      logic want_a;
      assign want_a = ~pick_b;  // active-low select
      clksel_lane #(.STAGES(SYNC_STAGES), .RISE(RISE_LANES)) u_lane_a (
        .clk(clk_a), .arst(arst), .want(want_a),
        .gate_on(gate_a), .lane_clk(lane_a_clk)
      );
      assign gate_b     = 1'b0;
      assign lane_b_clk = IDLE_LVL;
      assign clk_out    = lane_a_clk;

      if (RISE_LANES) begin : g_chk_hi
        a_r6_forced_high: assert property (@(posedge clk_a) disable iff (arst)
          !gate_a |-> clk_out);
      end else begin : g_chk_lo
        a_r6_forced_low: assert property (@(negedge clk_a) disable iff (arst)
          !gate_a |-> !clk_out);
      end
    end

  end else begin : g_fixed
    // R7: plain pass-through, select and reset play no part.
    assign gate_a     = (MODE == SEL_FIXED_A);
    assign gate_b     = ~gate_a;
    assign lane_a_clk = clk_a;
    assign lane_b_clk = clk_b;
    assign clk_out    = gate_a ? lane_a_clk : lane_b_clk;
  end

endmodule

// File: tb/dyn_clk_select_test.sv
`timescale 1ns/1ps
module dyn_clk_select_test;
  import clksel_pkg::*;

  localparam real TB_HALF = 2.5;    // 200 MHz bench clock
  localparam real A_HALF  = 17.0;   // ~29.4 MHz
  localparam real B_HALF  = 6.25;   // 80 MHz
  localparam real RUNT    = 6.25;   // shortest legal pulse
  localparam int  SETTLE  = 60;     // bench cycles (300 ns) after a change

  logic tb_clk = 1'b0;
  logic clk_a  = 1'b0;
  logic clk_b  = 1'b0;
  logic arst   = 1'b1;
  logic sel    = 1'b0;
  logic done   = 1'b0;

  int checks = 0;
  int errors = 0;

  wire [7:0] outs;

  initial forever #(TB_HALF) tb_clk = ~tb_clk;
  initial begin #0.3; forever #(A_HALF) clk_a = ~clk_a; end
  initial begin #0.1; forever #(B_HALF) clk_b = ~clk_b; end

  // Default-parameter instance (R9).
  dyn_clk_select uut (
    .clk_a(clk_a), .clk_b(clk_b), .pick_b(sel), .arst(arst), .clk_out(outs[0])
  );

  for (genvar i = 1; i < 8; i++) begin : g_var
    dyn_clk_select #(.MODE(clksel_mode_e'(i))) u_var (
      .clk_a(clk_a), .clk_b(clk_b), .pick_b(sel), .arst(arst), .clk_out(outs[i])
    );
  end

  string follow_tag [8] = '{"R1,R9", "R3", "R5", "R5", "R6", "R6", "R7", "R7"};
  string reset_tag  [8] = '{"R2,R9", "R3", "R5", "R5", "R6", "R6", "R7", "R7"};

  // Settled output expected for each mode index.
  function automatic logic model_out(int m, logic s, logic a, logic b);
    case (m)
      0, 1:    return s ? b : a;
      2:       return s & b;
      3:       return s ? b : 1'b1;
      4:       return s ? 1'b0 : a;
      5:       return s ? 1'b1 : a;
      6:       return a;
      default: return b;
    endcase
  endfunction

  // Output expected while arst is high.
  function automatic logic reset_out(int m, logic a, logic b);
    case (m)
      0, 3, 5: return 1'b1;
      1, 2, 4: return 1'b0;
      6:       return a;
      default: return b;
    endcase
  endfunction

  task automatic check(input logic got, input logic exp, input string tag, input int idx);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s inst %0d got %b expected %b at %0t", tag, idx, got, exp, $time);
    end
  endtask

  // Reference model, evaluated on every bench clock.
  int   quiet     = 0;
  int   rst_count = 0;
  logic prev_sel  = 1'b0;
  logic prev_arst = 1'b1;
  logic first_win = 1'b1;

  always @(negedge tb_clk) begin
    if (!done) begin
      if (arst) begin
        if (rst_count >= 2)
          for (int i = 0; i < 8; i++)
            check(outs[i], reset_out(i, clk_a, clk_b), reset_tag[i], i);
        rst_count++;
      end else begin
        if (prev_arst) quiet = 0;
        if (sel != prev_sel) begin
          quiet     = 0;
          first_win = 1'b0;
        end
        for (int i = 0; i < 8; i++) begin
          if (i >= 6)
            check(outs[i], model_out(i, sel, clk_a, clk_b), "R7", i);
          else if (quiet >= SETTLE)
            check(outs[i], model_out(i, sel, clk_a, clk_b),
                  first_win ? "R8" : follow_tag[i], i);
        end
        quiet++;
      end
      prev_sel  = sel;
      prev_arst = arst;
    end
  end

  // R4: pulse-width monitor on every output.
  for (genvar i = 0; i < 8; i++) begin : g_mon
    realtime last_edge = -1.0;
    always @(outs[i]) begin
      if (!done && last_edge >= 0.0) begin
        checks++;
        if ($realtime - last_edge < RUNT - 0.01) begin
          errors++;
          $display("FAIL R4 inst %0d pulse %0f ns expected >= %0f ns",
                   i, $realtime - last_edge, RUNT);
        end
      end
      last_edge = $realtime;
    end
  end

  initial begin
    repeat (20) @(posedge tb_clk);
    arst <= 1'b0;
    for (int k = 0; k < 40; k++) begin
      repeat ($urandom_range(80, 300)) @(posedge tb_clk);
      sel <= ~sel;
    end
    repeat (100) @(posedge tb_clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got hung expected completion");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule